// File: doc/BRIEF.md
# Command-Stepped I2C Bus Master

This block is an I2C bus master that software drives one primitive bus step at a time. A write to the command input picks a single step: a start condition, a one-byte write that captures the slave's acknowledge, a one-byte read that ends with the master's ACK, a one-byte read that ends with the master's NACK, or a stop condition. A whole transaction is the sequence of these steps that software issues. Address bytes, including the two-byte form used for 10-bit slave addresses, are ordinary written bytes. A repeated start is a start issued while the master still owns the bus.

Once a step finishes, the master keeps the bus suspended: SCL is held low and SDA keeps its last level until the next command arrives. Only a stop returns both lines to idle. Bit timing is set by a prescaler parameter. Each SCL period is four quarter periods, and each quarter period is `QDIV` clock cycles long. The pads are open-drain. The block outputs pull-low enables for both lines and reads the SDA line level back in.

Top module: `i2c_step_master`

## Requirements
- R1: After reset, busy and ack_seen are 0, rx_data is 0x00, and both pads are released (scl_oe = 0, sda_oe = 0).
- R2: The command code is cmd_wdata[3:0]. The codes are 1 = start, 2 = write byte, 3 = read byte then ACK, 4 = read byte then NACK, 5 = stop. Any other code is ignored and does not set busy.
- R3: An accepted command sets busy in the next cycle. Busy stays high for 4·QDIV cycles for a start or a stop, and for 36·QDIV cycles for a byte command.
- R4: A command written while busy is high is ignored. The running step, its duration and its result do not change.
- R5: While the bus is not owned (after reset or after a stop), only a start is accepted. Every other code is ignored.
- R6: A start releases SDA while SCL is low, raises SCL, and then pulls SDA low while SCL is high. Issued while the bus is owned, it forms a repeated start and no stop condition appears before it.
- R7: A write sends tx_data MSB first on 8 SCL pulses and releases SDA for the 9th pulse. ack_seen becomes 1 if SDA was low at the 9th pulse and 0 otherwise. ack_seen holds that value until the next accepted command clears it.
- R8: A read-then-ACK samples 8 bits MSB first on the SCL high phases, pulls SDA low for the 9th pulse, and places the byte on rx_data when the step ends.
- R9: A read-then-NACK samples a byte the same way, but leaves SDA released (high) for the 9th pulse.
- R10: A stop pulls SDA low while SCL is low, raises SCL, and then releases SDA while SCL is high. It leaves both pads released and the bus not owned.
- R11: While the bus is owned and no step is running, SCL is held low and SDA does not change.
- R12: During byte commands, SDA changes only while SCL is low. Only start and stop steps move SDA while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 32 | Command word; the code is in bits 3:0 |
| tx_data | input | 8 | Byte sent by a write command |
| rx_data | output | 8 | Last byte received by a read command |
| busy | output | 1 | A bus step is in progress |
| ack_seen | output | 1 | The slave acknowledged the last written byte |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA line level |

## Verification
A wrong quarter or bit count shows up at once as a busy pulse of the wrong length. It also shows as a shifted sample of the byte seen on the wire at SCL rising edges, both within the same command. A wrong ownership state shows up in two ways: a command that should be refused sets busy one cycle later, or the pads are released between steps when they should be held. A wrong line-level table for a phase shows up as a spurious or missing start or stop edge while SCL is high. It can also show as a wrong 9th-bit level, which is visible during that same bit period.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam int BYTE_W  = 8;
  localparam int FRAME_N = BYTE_W + 1;
  localparam int BIT_CW  = $clog2(FRAME_N + 1);

  typedef enum logic [3:0] {
    OP_NONE  = 4'h0,
    OP_START = 4'h1,
    OP_WRITE = 4'h2,
    OP_RDACK = 4'h3,
    OP_RDNAK = 4'h4,
    OP_STOP  = 4'h5
  } op_e;

  // start and stop are the only steps that move SDA with SCL high
  function automatic logic is_cond(input logic [3:0] op);
    return (op == OP_START) || (op == OP_STOP);
  endfunction

  function automatic logic is_read(input logic [3:0] op);
    return (op == OP_RDACK) || (op == OP_RDNAK);
  endfunction

  function automatic logic is_byte(input logic [3:0] op);
    return (op == OP_WRITE) || is_read(op);
  endfunction

  // acceptance rule: only a start when idle, any defined step when owned
  function automatic logic op_legal(input logic [3:0] op, input logic owned);
    return (op == OP_START) || (owned && (is_byte(op) || op == OP_STOP));
  endfunction

  // released levels {scl, sda} for quarter q of a step
  function automatic logic [1:0] quarter_lines(input logic [3:0] op,
                                               input logic [1:0] q,
                                               input logic       ack_slot,
                                               input logic       txbit);
    logic scl_r, sda_r;
    scl_r = (q == 2'd1) || (q == 2'd2);
    case (op)
      OP_START: sda_r = (q < 2'd2);
      OP_STOP: begin
        scl_r = (q != 2'd0);
        sda_r = (q >= 2'd2);
      end
      OP_WRITE: sda_r = ack_slot ? 1'b1 : txbit;
      OP_RDACK: sda_r = ack_slot ? 1'b0 : 1'b1;
      default:  sda_r = 1'b1;
    endcase
    return {scl_r, sda_r};
  endfunction

endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
  parameter int QDIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart || !run) cnt <= '0;
    else if (cnt == LAST)     cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  // every quarter starts from a zero count
  p_quarter_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));

endmodule

// File: rtl/i2cm_bytepath.sv
module i2cm_bytepath
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_tx,
  input  logic [BYTE_W-1:0] txd,
  input  logic              shift_tx,
  input  logic              clr_ack,
  input  logic              samp_bit,
  input  logic              samp_ack,
  input  logic              commit_rx,
  input  logic              sda_in,
  output logic              tx_cur,
  output logic              tx_nxt,
  output logic [BYTE_W-1:0] rxd,
  output logic              ack_seen
);
  logic [BYTE_W-1:0] tx_sh, rx_sh;

  assign tx_cur = tx_sh[BYTE_W-1];
  assign tx_nxt = tx_sh[BYTE_W-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh    <= '0;
      rx_sh    <= '0;
      rxd      <= '0;
      ack_seen <= 1'b0;
    end else begin
      if (load_tx)       tx_sh <= txd;
      else if (shift_tx) tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      if (samp_bit)      rx_sh <= {rx_sh[BYTE_W-2:0], sda_in};
      if (commit_rx)     rxd   <= rx_sh;
      if (clr_ack)       ack_seen <= 1'b0;
      else if (samp_ack) ack_seen <= ~sda_in;
    end
  end

  // acknowledge status only moves on a new command or the 9th-bit sample
  p_ack_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_ack && !samp_ack) |=> $stable(ack_seen));

endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [3:0] cmd_code,
  input  logic       txd_msb,
  input  logic       tick,
  input  logic       tx_cur,
  input  logic       tx_nxt,
  output logic       busy,
  output logic       owned,
  output logic       scl_rel,
  output logic       sda_rel,
  output logic       accept,
  output logic       done,
  output logic       shift_tx,
  output logic       samp_bit,
  output logic       samp_ack,
  output logic       commit_rx
);
  logic [3:0]        cmd_r;
  logic [1:0]        q, q_nx;
  logic [BIT_CW-1:0] bitn, bitn_nx;
  logic              last_q, step, bit_end, mid_high;

  assign accept   = cmd_we && !busy && op_legal(cmd_code, owned);
  assign step     = busy && tick;
  assign bit_end  = (q == 2'd3);
  assign last_q   = bit_end && (is_cond(cmd_r) || bitn == BIT_CW'(FRAME_N - 1));
  assign done     = step && last_q;
  assign q_nx     = q + 2'd1;
  assign bitn_nx  = bit_end ? bitn + 1'b1 : bitn;
  assign mid_high = step && (q == 2'd1) && is_byte(cmd_r);
  assign samp_bit = mid_high && is_read(cmd_r) && (bitn < BIT_CW'(BYTE_W));
  assign samp_ack = mid_high && (cmd_r == OP_WRITE) && (bitn == BIT_CW'(BYTE_W));
  assign shift_tx = step && bit_end && !last_q && (cmd_r == OP_WRITE);
  assign commit_rx = done && is_read(cmd_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      owned   <= 1'b0;
      cmd_r   <= OP_NONE;
      q       <= '0;
      bitn    <= '0;
      scl_rel <= 1'b1;
      sda_rel <= 1'b1;
    end else if (accept) begin
      busy  <= 1'b1;
      cmd_r <= cmd_code;
      q     <= '0;
      bitn  <= '0;
      {scl_rel, sda_rel} <= quarter_lines(cmd_code, 2'd0, 1'b0, txd_msb);
      if (cmd_code == OP_START) owned <= 1'b1;
    end else if (step) begin
      if (last_q) begin
        busy <= 1'b0;
        if (cmd_r == OP_STOP) owned <= 1'b0;
      end else begin
        q    <= q_nx;
        bitn <= bitn_nx;
        {scl_rel, sda_rel} <= quarter_lines(cmd_r, q_nx,
                                bitn_nx == BIT_CW'(BYTE_W),
                                bit_end ? tx_nxt : tx_cur);
      end
    end
  end

  p_busy_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_ignore_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_we && !done) |=> (busy && $stable(cmd_r)));

  p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!owned && !busy) |-> (scl_rel && sda_rel));

  p_hold_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && !busy && !cmd_we) |=> (!scl_rel && $stable(sda_rel)));

  p_sda_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_byte(cmd_r) && scl_rel) |=> (!scl_rel || $stable(sda_rel)));

endmodule

// File: rtl/i2c_step_master.sv
module i2c_step_master
  import i2cm_pkg::*;
#(
  parameter int QDIV = 125
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  input  logic [7:0]  tx_data,
  output logic [7:0]  rx_data,
  output logic        busy,
  output logic        ack_seen,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in
);
  logic [3:0] code;
  logic       unused_hi;
  logic       owned, scl_rel, sda_rel, accept, done;
  logic       shift_tx, samp_bit, samp_ack, commit_rx;
  logic       tick, tx_cur, tx_nxt, load_tx;

  assign code      = cmd_wdata[3:0];
  assign unused_hi = ^cmd_wdata[31:4];
  assign load_tx   = accept && (code == OP_WRITE);
  assign scl_oe    = ~scl_rel;
  assign sda_oe    = ~sda_rel;

  i2cm_qtick #(.QDIV(QDIV)) u_qtick (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(accept), .tick(tick)
  );

  i2cm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(code),
    .txd_msb(tx_data[BYTE_W-1]), .tick(tick), .tx_cur(tx_cur), .tx_nxt(tx_nxt),
    .busy(busy), .owned(owned), .scl_rel(scl_rel), .sda_rel(sda_rel),
    .accept(accept), .done(done), .shift_tx(shift_tx), .samp_bit(samp_bit),
    .samp_ack(samp_ack), .commit_rx(commit_rx)
  );

  i2cm_bytepath u_bytes (
    .clk(clk), .rst_n(rst_n), .load_tx(load_tx), .txd(tx_data),
    .shift_tx(shift_tx), .clr_ack(accept), .samp_bit(samp_bit),
    .samp_ack(samp_ack), .commit_rx(commit_rx), .sda_in(sda_in),
    .tx_cur(tx_cur), .tx_nxt(tx_nxt), .rxd(rx_data), .ack_seen(ack_seen)
  );

  // a refused command never raises busy
  p_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_we && !op_legal(code, owned)) |=> !busy);

endmodule

// File: tb/test_i2c_step_master.sv
`timescale 1ns/1ps
module test_i2c_step_master;
  localparam int Q  = 3;
  localparam int NV = 9;
  localparam int WD_LIMIT = 100000;

  // vector: [28:25] code, [24:17] tx byte, [16:8] slave drive per bit, [7:0] expected
  localparam logic [28:0] VEC [NV] = '{
    {4'h1, 8'h00, 9'h1FF, 8'h00},
    {4'h2, 8'hA0, 9'h1FE, 8'h01},
    {4'h2, 8'h3C, 9'h1FF, 8'h00},
    {4'h1, 8'h00, 9'h1FF, 8'h00},
    {4'h2, 8'hA1, 9'h1FE, 8'h01},
    {4'h3, 8'h00, {8'h5A, 1'b1}, 8'h5A},
    {4'h3, 8'h00, {8'h81, 1'b1}, 8'h81},
    {4'h4, 8'h00, {8'hC3, 1'b1}, 8'hC3},
    {4'h5, 8'h00, 9'h1FF, 8'h00}
  };

  logic        clk = 0, rst_n = 0, cmd_we = 0;
  logic [31:0] cmd_wdata = '0;
  logic [7:0]  tx_data = '0, rx_data;
  logic        busy, ack_seen, scl_oe, sda_oe;
  logic        scl_line, sda_line, slave_level;
  logic [8:0]  pat = 9'h1FF, mon = '0;
  int          fall_cnt = 0, base = 0, n_start = 0, n_stop = 0, bad = 0;
  int          nchk = 0, nfail = 0;
  logic        byte_active = 0;

  always #4 clk = ~clk;

  i2c_step_master #(.QDIV(Q)) i_i2c_step_master (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .tx_data(tx_data), .rx_data(rx_data), .busy(busy), .ack_seen(ack_seen),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  // bus and a scripted slave that changes its level only after SCL falls
  assign scl_line = ~scl_oe;
  always_comb begin
    int idx;
    idx = fall_cnt - base;
    slave_level = (idx >= 0 && idx <= 8) ? pat[8 - idx] : 1'b1;
  end
  assign sda_line = ~sda_oe & slave_level;

  always @(negedge scl_line) fall_cnt++;
  always @(posedge scl_line) mon <= {mon[7:0], sda_line};
  always @(negedge sda_line) if (scl_line) n_start++;
  always @(posedge sda_line) if (scl_line) n_stop++;
  always @(sda_line) if (scl_line && byte_active) bad++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c, input logic [7:0] d, output int dur);
    @(negedge clk);
    cmd_we = 1; cmd_wdata = {28'h0, c}; tx_data = d; base = fall_cnt;
    @(negedge clk);
    cmd_we = 0; dur = 0;
    while (busy) begin dur++; @(negedge clk); end
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    $display("FAIL watchdog actual=%0d expected=done", WD_LIMIT);
    $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
    $finish;
  end

  initial begin
    int dur, s0, p0;
    logic [3:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 ack", ack_seen, 0);
    chk("R1 rx", rx_data, 8'h00);
    chk("R1 pads", {scl_oe, sda_oe}, 2'b00);

    // R5 a byte command on an idle bus is refused
    issue(4'h2, 8'hFF, dur);
    chk("R5 idle write refused", dur, 0);
    chk("R5 pads still released", {scl_oe, sda_oe}, 2'b00);

    for (int i = 0; i < NV; i++) begin
      c = VEC[i][28:25];
      pat = VEC[i][16:8];
      s0 = n_start; p0 = n_stop;
      byte_active = (c >= 4'h2 && c <= 4'h4);
      issue(c, VEC[i][24:17], dur);
      byte_active = 0;
      // R3 step length
      chk("R3 busy length", dur, (c == 4'h1 || c == 4'h5) ? 4 * Q : 36 * Q);
      case (c)
        4'h1: begin
          chk("R6 start edge", n_start - s0, 1);
          chk("R6 no stop before start", n_stop - p0, 0);
        end
        4'h2: begin
          chk("R7 byte on wire", mon[8:1], VEC[i][24:17]);
          chk("R7 ack status", ack_seen, VEC[i][0]);
        end
        4'h3: begin
          chk("R8 rx byte", rx_data, VEC[i][7:0]);
          chk("R8 master ACK low", mon[0], 1'b0);
          chk("R7 ack cleared by read", ack_seen, 0);
        end
        4'h4: begin
          chk("R9 rx byte", rx_data, VEC[i][7:0]);
          chk("R9 master NACK high", mon[0], 1'b1);
        end
        default: begin
          chk("R10 stop edge", n_stop - p0, 1);
          chk("R10 pads released", {scl_oe, sda_oe}, 2'b00);
        end
      endcase
      if (c != 4'h5) chk("R11 SCL held low", scl_oe, 1'b1);
    end
    chk("R12 no SDA edge with SCL high in bytes", bad, 0);

    // R2 undefined code refused while owned
    pat = 9'h1FF;
    issue(4'h1, 8'h00, dur);
    issue(4'hB, 8'h00, dur);
    chk("R2 unknown code refused", dur, 0);

    // R4 a command written during a write is ignored
    pat = 9'h1FE;
    @(negedge clk);
    cmd_we = 1; cmd_wdata = 32'h2; tx_data = 8'h55; base = fall_cnt;
    @(negedge clk);
    cmd_we = 1; cmd_wdata = 32'h4; dur = 1;
    @(negedge clk);
    cmd_we = 0;
    while (busy) begin dur++; @(negedge clk); end
    chk("R4 length unchanged", dur, 36 * Q);
    chk("R4 result from write", ack_seen, 1'b1);
    chk("R4 rx untouched", rx_data, 8'hC3);
    chk("R4 byte on wire", mon[8:1], 8'h55);

    // R11 bus held while owned and idle
    begin
      logic held, sda0;
      held = 1; sda0 = sda_oe;
      repeat (40) begin
        @(negedge clk);
        if (scl_oe !== 1'b1 || sda_oe !== sda0) held = 0;
      end
      chk("R11 hold between steps", held, 1'b1);
    end

    pat = 9'h1FF;
    issue(4'h5, 8'h00, dur);
    chk("R10 final stop length", dur, 4 * Q);
    chk("R10 final pads released", {scl_oe, sda_oe}, 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule